// File: doc/BRIEF.md
# Flash Segment Address Decoder

This block sits between a processor's flash aperture and a serial flash controller. The aperture is a 1 GiB window. Software divides it at run time into up to three segments, one for each flash chip select. Each segment is described by a single 32-bit register holding its first and last 64 KiB unit. The window base is fixed by a parameter. Segment offsets are always counted from that base.

For every access, the block compares the address against all enabled segments in parallel. It then reports which chip select owns the access and where the access falls inside that segment. An access that no segment covers is flagged as a miss. On a miss the flash strobes stay low, writes are discarded and reads return all ones. For each segment the block also drives the decoded absolute base and byte size, so that neighbouring logic or a status view can show them.

Top module: `flash_seg_decoder`

## Requirements
- R1: Each segment register is laid out as bits [15:0] = first 64 KiB unit and bits [31:16] = last 64 KiB unit, inclusive. After reset, segment 0 holds 0x08000000, segment 1 holds 0x10000800, and any further segment holds zero.
- R2: An access hits segment i only when all of the following are true: the register is nonzero, the unit of its first byte is at or above the first-unit field, and the unit of its last byte is at or below the last-unit field. The access width is 2^acc_size bytes (codes 0..3 give 1, 2, 4 and 8 bytes).
- R3: When several segments hit, acc_cs reports the lowest-numbered one.
- R4: On a hit, acc_offset equals acc_addr minus (first unit × 65536). flash_re or flash_we is raised, following acc_write. acc_rdata passes flash_rdata through.
- R5: On a miss with acc_valid high, the following hold: acc_miss is 1, flash_re and flash_we are 0, acc_rdata is all ones, and acc_cs and acc_offset are 0.
- R6: A register value of zero disables its segment. Such a segment matches nothing, reports size 0 and reports base equal to the window base.
- R7: For an enabled, ordered segment, the reported base is the window base plus first unit × 65536. The reported size is last unit × 65536 + 65536 − first unit × 65536.
- R8: A nonzero register whose last unit is below its first unit matches nothing and reports size 0.
- R9: A register write is applied at the clock edge where cfg_we is sampled. An access presented in the same cycle as the write still decodes against the old value. Decoding is combinational.
- R10: A write to an index at or above the segment count changes no register. Reading such an index returns zero.
- R11: cfg_rdata returns the stored register value of the selected segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_idx | input | 3 | Segment register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_idx |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | Access is a write |
| acc_size | input | 2 | Access width code, bytes = 2^code |
| acc_addr | input | 30 | Byte offset within the window |
| flash_rdata | input | 64 | Read data from the flash side |
| acc_cs | output | 2 | Selected chip select |
| acc_offset | output | 30 | Offset inside the selected segment |
| acc_miss | output | 1 | No enabled segment covers the access |
| flash_re | output | 1 | Read forwarded to flash |
| flash_we | output | 1 | Write forwarded to flash |
| acc_rdata | output | 64 | Read data returned to the requester |
| seg_base | output | 120 | Decoded base per segment, 40 bits each, segment 0 lowest |
| seg_size | output | 99 | Decoded size per segment, 33 bits each, segment 0 lowest |

## Verification
A corrupted or stale segment register appears first in cfg_rdata, seg_base and seg_size, in the cycle after the faulty write. It also changes the chip select or the miss flag for any address near that segment's edges in the same cycle. A broken priority chain only shows up where segments overlap, which the reset layout already provides at unit 0x0800. Straddling accesses at unit boundaries reveal a decoder that checks only the first byte of an access. Writes to out-of-range indices reveal a decoder that aliases the index.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  localparam int UNIT_SH = 16;
  localparam int REG_W   = 32;
  localparam int UNIT_W  = REG_W - UNIT_SH;

  typedef struct packed {
    logic [UNIT_W-1:0] last_u;
    logic [UNIT_W-1:0] first_u;
  } seg_reg_t;

  function automatic seg_reg_t seg_reset_value(input int idx);
    case (idx)
      0:       return seg_reg_t'(32'h0800_0000);
      1:       return seg_reg_t'(32'h1000_0800);
      default: return seg_reg_t'(32'h0000_0000);
    endcase
  endfunction

endpackage

// File: rtl/fsd_regfile.sv
module fsd_regfile
  import fsd_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output seg_reg_t         seg_q [NUM_CS]
);

  logic [NUM_CS-1:0] load_en;

  always_comb begin
    load_en   = '0;
    cfg_rdata = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cfg_idx == IDX_W'(i)) begin
        load_en[i] = cfg_we;
        cfg_rdata  = seg_q[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= seg_reset_value(g);
      end else if (load_en[g]) begin
        seg_q[g] <= seg_reg_t'(cfg_wdata);
      end
    end

    // R9: a write lands at the sampling edge
    p_write_lands_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == IDX_W'(g)) |=> (seg_q[g] == $past(cfg_wdata)));

    // R10: an out-of-range index leaves every register alone
    p_oob_ignored_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && ({1'b0, cfg_idx} >= (IDX_W+1)'(NUM_CS))) |=> $stable(seg_q[g]));
  end

endmodule

// File: rtl/fsd_window.sv
module fsd_window
  import fsd_pkg::*;
#(
  parameter int          SYS_AW   = 40,
  parameter logic [39:0] WIN_BASE = 40'h01_0000_0000,
  localparam int         SIZE_W   = REG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seg_reg_t          seg,
  input  logic [UNIT_W-1:0] first_u,
  input  logic [UNIT_W-1:0] last_u,
  output logic              match,
  output logic [SYS_AW-1:0] base,
  output logic [SIZE_W-1:0] size
);

  logic enabled;
  logic ordered;
  logic [SIZE_W-1:0] first_b;
  logic [SIZE_W-1:0] last_b;

  always_comb begin
    enabled = (seg != '0);
    ordered = (seg.last_u >= seg.first_u);
    first_b = SIZE_W'({seg.first_u, {UNIT_SH{1'b0}}});
    last_b  = SIZE_W'({seg.last_u,  {UNIT_SH{1'b0}}});
    match   = enabled && ordered && (first_u >= seg.first_u) && (last_u <= seg.last_u);
    if (enabled && ordered) begin
      size = last_b + (SIZE_W'(1) << UNIT_SH) - first_b;
    end else begin
      size = '0;
    end
    if (enabled) begin
      base = WIN_BASE[SYS_AW-1:0] + SYS_AW'(first_b);
    end else begin
      base = WIN_BASE[SYS_AW-1:0];
    end
  end

  // R8: a match only ever comes from a segment with a nonzero extent
  p_match_has_size_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (size != '0));

  // R6: a cleared register never matches
  p_zero_no_match_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (seg == '0) |-> !match);

endmodule

// File: rtl/fsd_select.sv
module fsd_select
  import fsd_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int CS_W   = 2,
  parameter int WIN_AW = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [NUM_CS-1:0] match,
  input  seg_reg_t          seg_q [NUM_CS],
  input  logic [UNIT_W-1:0] first_u,
  input  logic [UNIT_SH-1:0] addr_lo,
  output logic              hit,
  output logic [CS_W-1:0]   sel_cs,
  output logic [WIN_AW-1:0] offset
);

  logic [NUM_CS-1:0] grant;
  logic [UNIT_W-1:0] rel_u;

  always_comb begin
    grant  = '0;
    sel_cs = '0;
    rel_u  = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        grant  = '0;
        grant[i] = 1'b1;
        sel_cs = CS_W'(i);
        rel_u  = first_u - seg_q[i].first_u;
      end
    end
    hit = acc_valid && (grant != '0);
    if (!hit) begin
      sel_cs = '0;
      rel_u  = '0;
    end
    offset = hit ? WIN_AW'({rel_u, addr_lo}) : '0;
  end

  // R3: at most one segment is granted
  p_grant_onehot_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3: the granted segment is one that matched
  p_grant_matched_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match[sel_cs]);

endmodule

// File: rtl/flash_seg_decoder.sv
module flash_seg_decoder
  import fsd_pkg::*;
#(
  parameter int          NUM_CS   = 3,
  parameter int          WIN_AW   = 30,
  parameter int          SYS_AW   = 40,
  parameter logic [39:0] WIN_BASE = 40'h01_0000_0000,
  parameter int          DATA_W   = 64,
  localparam int         CS_W     = (NUM_CS < 2) ? 1 : $clog2(NUM_CS),
  localparam int         IDX_W    = CS_W + 1,
  localparam int         SIZE_W   = REG_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [REG_W-1:0]         cfg_wdata,
  output logic [REG_W-1:0]         cfg_rdata,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [1:0]               acc_size,
  input  logic [WIN_AW-1:0]        acc_addr,
  input  logic [DATA_W-1:0]        flash_rdata,
  output logic [CS_W-1:0]          acc_cs,
  output logic [WIN_AW-1:0]        acc_offset,
  output logic                     acc_miss,
  output logic                     flash_re,
  output logic                     flash_we,
  output logic [DATA_W-1:0]        acc_rdata,
  output logic [NUM_CS*SYS_AW-1:0] seg_base,
  output logic [NUM_CS*SIZE_W-1:0] seg_size
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  seg_reg_t seg_q [NUM_CS];

  fsd_regfile #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .seg_q     (seg_q)
  );

  // unit of the first and of the last byte of the access
  logic [UNIT_W-1:0] first_u;
  logic [UNIT_W-1:0] last_u;

  always_comb begin
    first_u = UNIT_W'(acc_addr >> UNIT_SH);
    last_u  = UNIT_W'((REG_W'(acc_addr) + ((REG_W'(1) << acc_size) - REG_W'(1))) >> UNIT_SH);
  end

  logic [NUM_CS-1:0] match;
  logic [SIZE_W-1:0] size_arr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    fsd_window #(.SYS_AW(SYS_AW), .WIN_BASE(WIN_BASE)) u_win (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .seg     (seg_q[g]),
      .first_u (first_u),
      .last_u  (last_u),
      .match   (match[g]),
      .base    (seg_base[g*SYS_AW +: SYS_AW]),
      .size    (size_arr[g])
    );
    assign seg_size[g*SIZE_W +: SIZE_W] = size_arr[g];
  end

  logic hit;

  fsd_select #(.NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_AW(WIN_AW)) u_select (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_valid (acc_valid),
    .match     (match),
    .seg_q     (seg_q),
    .first_u   (first_u),
    .addr_lo   (acc_addr[UNIT_SH-1:0]),
    .hit       (hit),
    .sel_cs    (acc_cs),
    .offset    (acc_offset)
  );

  always_comb begin
    acc_miss  = acc_valid && !hit;
    flash_re  = hit && !acc_write;
    flash_we  = hit && acc_write;
    acc_rdata = hit ? flash_rdata : '1;
  end

  // R5: a missed access never reaches the flash and reads all ones
  p_miss_dropped_r5 : assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_miss |-> (!flash_we && !flash_re && (acc_rdata == '1)));

  // R4: the reported offset stays inside the selected segment
  p_offset_inside_r4 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && !acc_miss) |-> (SIZE_W'(acc_offset) < size_arr[acc_cs]));

endmodule

// File: tb/flash_seg_decoder_bench.sv
module flash_seg_decoder_bench;

  localparam logic [39:0] WB = 40'h01_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_size;
  logic [29:0] acc_addr;
  logic [63:0] flash_rdata;
  logic [1:0]  acc_cs;
  logic [29:0] acc_offset;
  logic        acc_miss, flash_re, flash_we;
  logic [63:0] acc_rdata;
  logic [119:0] seg_base;
  logic [98:0]  seg_size;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_reg [3];

  always #4 clk = ~clk;

  flash_seg_decoder u_flash_seg_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_size(acc_size), .acc_addr(acc_addr),
    .flash_rdata(flash_rdata), .acc_cs(acc_cs), .acc_offset(acc_offset),
    .acc_miss(acc_miss), .flash_re(flash_re), .flash_we(flash_we),
    .acc_rdata(acc_rdata), .seg_base(seg_base), .seg_size(seg_size)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_size(input logic [31:0] r);
    if (r == 0 || r[31:16] < r[15:0]) return 33'd0;
    return {1'b0, r[31:16], 16'h0} + 33'h10000 - {1'b0, r[15:0], 16'h0};
  endfunction

  function automatic logic [39:0] exp_base(input logic [31:0] r);
    return WB + {8'h0, r[15:0], 16'h0};
  endfunction

  function automatic void model(input logic [29:0] a, input logic [1:0] sz,
                                output bit hit, output int cs, output logic [29:0] off);
    logic [31:0] last;
    hit = 0; cs = 0; off = '0;
    last = {2'b0, a} + (32'd1 << sz) - 32'd1;
    for (int i = 0; i < 3; i++) begin
      if (!hit && m_reg[i] != 0 && m_reg[i][31:16] >= m_reg[i][15:0] &&
          {2'b0, a[29:16]} >= m_reg[i][15:0] && last[31:16] <= m_reg[i][31:16]) begin
        hit = 1; cs = i;
        off = 30'({2'b0, a} - {m_reg[i][15:0], 16'h0});
      end
    end
  endfunction

  task automatic wr(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 3) m_reg[idx] = v;
  endtask

  task automatic acc(input string req, input logic [29:0] a, input logic [1:0] sz, input bit w);
    bit h; int cs; logic [29:0] off;
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = w;
    flash_rdata = {$urandom, $urandom};
    #1;
    model(a, sz, h, cs, off);
    chk({req, " miss"}, 64'(acc_miss), 64'(!h));
    chk({req, " cs"}, 64'(acc_cs), 64'(cs));
    chk({req, " offset"}, 64'(acc_offset), 64'(off));
    chk({req, " we/re"}, 64'({flash_we, flash_re}), 64'({h && w, h && !w}));
    chk({req, " rdata"}, acc_rdata, h ? flash_rdata : '1);
  endtask

  task automatic rb(input string req, input logic [2:0] idx);
    cfg_idx = idx; #1;
    chk({req, " readback"}, 64'(cfg_rdata), 64'(idx < 3 ? m_reg[idx] : 32'h0));
    if (idx < 3) begin
      chk({req, " base"}, 64'(seg_base[idx*40 +: 40]), 64'(exp_base(m_reg[idx])));
      chk({req, " size"}, 64'(seg_size[idx*33 +: 33]), 64'(exp_size(m_reg[idx])));
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0;
    acc_valid = 0; acc_write = 0; acc_size = 0; acc_addr = 0; flash_rdata = 0;
    m_reg[0] = 32'h0800_0000; m_reg[1] = 32'h1000_0800; m_reg[2] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 / R7 reset layout and decoded values
    rb("R1 R7 cs0", 3'd0);
    rb("R1 R7 cs1", 3'd1);
    rb("R1 cs2", 3'd2);
    chk("R7 cs0 size", 64'(seg_size[32:0]), 64'h0801_0000);
    chk("R7 cs1 base", 64'(seg_base[79:40]), 64'h01_0800_0000);

    @(negedge clk); acc("R2 start of cs0", 30'h0, 2'd2, 0);
    @(negedge clk); acc("R3 overlap unit", 30'h0800_0000, 2'd3, 0);
    chk("R3 lowest wins", 64'(acc_cs), 64'd0);
    @(negedge clk); acc("R4 cs1 write", 30'h0801_0000, 2'd2, 1);
    chk("R4 offset", 64'(acc_offset), 64'h1_0000);
    @(negedge clk); acc("R5 miss write", 30'h1001_0000, 2'd1, 1);
    chk("R5 miss flag", 64'(acc_miss), 64'd1);
    @(negedge clk); acc("R2 straddle 8B", 30'h1000_FFFC, 2'd3, 0);
    chk("R2 straddle misses", 64'(acc_miss), 64'd1);
    @(negedge clk); acc("R2 fits 4B", 30'h1000_FFFC, 2'd2, 0);
    chk("R2 fit hits cs1", 64'({acc_miss, acc_cs}), 64'd1);

    // R9: write and access in the same cycle
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'd2; cfg_wdata = 32'h2000_2000;
    acc("R9 same cycle old value", 30'h2000_0000, 2'd0, 0);
    @(negedge clk);
    cfg_we = 0; m_reg[2] = 32'h2000_2000;
    acc("R9 next cycle new value", 30'h2000_0000, 2'd0, 0);
    chk("R9 cs2 selected", 64'(acc_cs), 64'd2);

    // R8 inverted segment
    wr(3'd2, 32'h1000_2000);
    acc("R8 inverted", 30'h2000_0000, 2'd0, 0);
    rb("R8 size zero", 3'd2);

    // R6 disable
    wr(3'd0, 32'h0);
    rb("R6 disabled cs0", 3'd0);
    chk("R6 base is window base", 64'(seg_base[39:0]), 64'(WB));
    acc("R6 no match", 30'h10, 2'd0, 0);

    // R10 out-of-range index
    wr(3'd3, 32'hDEAD_BEEF);
    rb("R10 idx3", 3'd3);
    rb("R10 cs0 kept", 3'd0);
    rb("R10 cs1 kept", 3'd1);
    rb("R10 cs2 kept", 3'd2);

    // random configurations and accesses (R2 R3 R4 R5 R7 R11)
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 3; i++) begin
        logic [15:0] s, e;
        int k;
        k = $urandom % 8;
        s = 16'($urandom % 16'h4000);
        e = (k == 0) ? s - 16'd1 : 16'(s + ($urandom % 16'h0200));
        if (e > 16'h3FFF) e = 16'h3FFF;
        wr(3'(i), (k == 1) ? 32'h0 : {e, s});
        rb("R11 R7 random", 3'(i));
      end
      for (int j = 0; j < 20; j++) begin
        logic [15:0] u;
        logic [15:0] lo;
        int pick;
        pick = $urandom % 3;
        u = 16'(m_reg[pick][15:0] + ($urandom % (32'(m_reg[pick][31:16]) - 32'(m_reg[pick][15:0]) + 3)) - 1);
        lo = ($urandom % 4 == 0) ? 16'(16'hFFF8 + $urandom % 8) : 16'($urandom);
        @(negedge clk);
        acc("R2 R3 R4 R5 random", ($urandom % 4 == 0) ? 30'($urandom) : {u[13:0], lo},
            2'($urandom), 1'($urandom));
      end
    end

    acc_valid = 0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule